// File: doc/BRIEF.md
# Page Buffer Column Pointer

This block keeps the column pointer for a page register of 528 bytes. The register is split into three areas: a lower half (bytes 0 to 255), an upper half (bytes 256 to 511) and a spare tail of 16 bytes (512 to 527). An area-select event chooses the area. A column-load event then places the pointer at an offset inside that area. From there, each read or write strobe steps the pointer forward by one byte. The output index addresses the buffer RAM, which lives outside this block.

The selected area is sticky and depends on history. The upper half is good for one access only: once a column has been loaded through it, the selection returns to the lower half. The spare area keeps its selection until another select or a reset. A spare-disable input changes where a sequential read in the halves ends. When a read passes the final column, the pointer wraps for the next page and a one-cycle page-advance pulse is raised, so that an outer sequencer can fetch that page. All events are single-cycle pulses that are sampled on the rising clock edge. Every output is registered, except the end-of-page flag, which is decoded from registered state.

Top module: `page_ptr_unit`

## Requirements
- R1: When `rst_n` is low, or when `soft_rst` is high, at a clock edge, `buf_idx` becomes 0, `page_adv` becomes 0 and the selected area becomes the lower half.
- R2: `sel_vld` with `sel_code` = 2'b00 selects the lower half. A following `col_load` sets `buf_idx` to `col_byte`. A `sel_code` of 2'b11 changes nothing.
- R3: `sel_code` = 2'b01 selects the upper half, so that the next `col_load` sets `buf_idx` to 256 + `col_byte`. That load returns the selection to the lower half, so a second load with no new select sets `buf_idx` to `col_byte`.
- R4: `sel_code` = 2'b10 while `spare_off` is low selects the spare area. A `col_load` then sets `buf_idx` to 512 + `col_byte[3:0]`, and `col_byte[7:4]` is ignored.
- R5: A spare select (`sel_code` = 2'b10) while `spare_off` is high has no effect. The area selected before it stays in force.
- R6: Each `rd_stb` below the end column raises `buf_idx` by one on the next clock edge.
- R7: The end column is 527 in the spare area. In either half it is 511 when `spare_off` is high and 527 when it is low. `at_last` is high whenever `buf_idx` is at or beyond the end column.
- R8: An `rd_stb` while `at_last` is high moves `buf_idx` to 0 in either half and sets `page_adv` high for exactly one cycle. `page_adv` is never high except after such a read.
- R9: In the spare area, an `rd_stb` at column 527 wraps `buf_idx` to 512 plus the spare offset given by the last column load.
- R10: Each `wr_stb` raises `buf_idx` by one. At column 527 the write is dropped and `buf_idx` stays at 527.
- R11: `op_done` returns an upper-half selection to the lower half. It leaves a lower-half or spare selection unchanged, and it does not move `buf_idx`.
- R12: When events coincide, the order of priority is: reset, then `col_load`, then `rd_stb`, then `wr_stb`. With no event, `buf_idx` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Reset command pulse |
| sel_vld | input | 1 | Area-select command pulse |
| sel_code | input | 2 | Area code: 00 lower, 01 upper, 10 spare, 11 none |
| col_load | input | 1 | Column address cycle pulse |
| col_byte | input | COL_W (8) | Column offset within the area |
| spare_off | input | 1 | High: spare area deselected |
| rd_stb | input | 1 | Read strobe (one per byte read) |
| wr_stb | input | 1 | Data-write strobe (one per byte loaded) |
| op_done | input | 1 | Program or erase finished pulse |
| buf_idx | output | IDX_W (10) | Page buffer byte index |
| at_last | output | 1 | Pointer at or past the end column |
| page_adv | output | 1 | One-cycle request to fetch the next page |

## Verification
Column loads are tried in all three areas, each with and without a preceding select. This separates the sticky spare selection from the one-shot upper half, and it shows the fallback both after a load and after `op_done`. Read runs are made to cross the 511 boundary with `spare_off` at both levels, which tells the two end columns apart. A run that starts mid-spare tells a wrap back to the spare offset from a wrap to column zero. Runs of writes into 527 show saturation, and coincident strobes together with the ignored select codes check the priority order and the inputs that must have no effect.

// File: rtl/pbp_pkg.sv
// Shared types for the page buffer pointer.
// Assumes a buffer split into two equal halves plus one spare tail.
package pbp_pkg;

    // Area selected by the pointer-select commands.
    typedef enum logic [1:0] {
        AREA_LO    = 2'b00,
        AREA_HI    = 2'b01,
        AREA_SPARE = 2'b10
    } area_e;

    // Raw select code that selects nothing.
    localparam logic [1:0] SEL_NONE = 2'b11;

endpackage

// File: rtl/pbp_area_ctl.sv
// Area selection state.
// Holds the sticky area choice. The upper half is one-shot: a column load
// or a finished program/erase returns it to the lower half. A spare select
// is refused while the spare area is disabled.
// Assumes single-cycle event pulses and a synchronous active-low reset.
module pbp_area_ctl
    import pbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       sel_vld,
    input  logic [1:0] sel_code,
    input  logic       spare_off,
    input  logic       col_load,
    input  logic       op_done,
    output area_e      area_q
);

    area_e area_d;

    // Next-area decode from the command events.
    always_comb begin
        area_d = area_q;
        if (sel_vld) begin
            case (sel_code)
                2'b00:   area_d = AREA_LO;
                2'b01:   area_d = AREA_HI;
                2'b10:   area_d = spare_off ? area_q : AREA_SPARE;
                default: area_d = area_q;
            endcase
        end else if ((col_load || op_done) && area_q == AREA_HI) begin
            area_d = AREA_LO;
        end
    end

    // Area register with reset to the lower half.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            area_q <= AREA_LO;
        end else begin
            area_q <= area_d;
        end
    end

endmodule

// File: rtl/pbp_span.sv
// Address arithmetic for the current area.
// Gives the index that a column load produces, the end column of a
// sequential read and the index that a read wraps to at the end of a page.
// Purely combinational; assumes MAIN_BYTES is even and SPARE_BYTES a power of two.
module pbp_span
    import pbp_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int COL_W       = 8,
    parameter int SPARE_W     = 4,
    parameter int IDX_W       = 10
)(
    input  area_e              area,
    input  logic               spare_off,
    input  logic [COL_W-1:0]   col_byte,
    input  logic [SPARE_W-1:0] spare_start,
    output logic [IDX_W-1:0]   load_idx,
    output logic [IDX_W-1:0]   end_col,
    output logic [IDX_W-1:0]   wrap_idx
);

    localparam int HALF_BYTES = MAIN_BYTES / 2;
    localparam int LAST_MAIN  = MAIN_BYTES - 1;
    localparam int LAST_ALL   = MAIN_BYTES + SPARE_BYTES - 1;

    // Base plus offset for a column address cycle.
    always_comb begin
        case (area)
            AREA_HI:    load_idx = IDX_W'(HALF_BYTES) + IDX_W'(col_byte);
            AREA_SPARE: load_idx = IDX_W'(MAIN_BYTES) + IDX_W'(col_byte[SPARE_W-1:0]);
            default:    load_idx = IDX_W'(col_byte);
        endcase
    end

    // Last column of a sequential read.
    always_comb begin
        if (area == AREA_SPARE || !spare_off) begin
            end_col = IDX_W'(LAST_ALL);
        end else begin
            end_col = IDX_W'(LAST_MAIN);
        end
    end

    // Restart point on the next page.
    always_comb begin
        if (area == AREA_SPARE) begin
            wrap_idx = IDX_W'(MAIN_BYTES) + IDX_W'(spare_start);
        end else begin
            wrap_idx = '0;
        end
    end

endmodule

// File: rtl/pbp_col_ctr.sv
// Column counter.
// Loads on a column cycle, steps on read and write strobes, wraps reads at
// the end column with a registered page-advance pulse and saturates writes
// at the final buffer byte.
// Priority: reset, load, read, write.
module pbp_col_ctr #(
    parameter int IDX_W    = 10,
    parameter int SPARE_W  = 4,
    parameter int LAST_ALL = 527
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               col_load,
    input  logic               rd_stb,
    input  logic               wr_stb,
    input  logic [IDX_W-1:0]   load_idx,
    input  logic [SPARE_W-1:0] load_start,
    input  logic [IDX_W-1:0]   end_col,
    input  logic [IDX_W-1:0]   wrap_idx,
    output logic [IDX_W-1:0]   idx_q,
    output logic [SPARE_W-1:0] start_q,
    output logic               adv_q,
    output logic               at_end
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LAST_ALL);

    // End-of-page decode from the registered index.
    always_comb begin
        at_end = (idx_q >= end_col);
    end

    // Index, spare start offset and page-advance pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            idx_q   <= '0;
            start_q <= '0;
            adv_q   <= 1'b0;
        end else begin
            adv_q <= 1'b0;
            if (col_load) begin
                idx_q   <= load_idx;
                start_q <= load_start;
            end else if (rd_stb) begin
                if (at_end) begin
                    idx_q <= wrap_idx;
                    adv_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end else if (wr_stb) begin
                if (idx_q < TOP_IDX) begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/page_ptr_unit.sv
// Page buffer column pointer, top level.
// Joins the area state, the address arithmetic and the column counter.
// Assumes that the command decode outside presents one-cycle pulses.
module page_ptr_unit
    import pbp_pkg::*;
#(
    parameter int  MAIN_BYTES  = 512,
    parameter int  SPARE_BYTES = 16,
    localparam int COL_W       = $clog2(MAIN_BYTES / 2),
    localparam int IDX_W       = $clog2(MAIN_BYTES + SPARE_BYTES)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             sel_vld,
    input  logic [1:0]       sel_code,
    input  logic             col_load,
    input  logic [COL_W-1:0] col_byte,
    input  logic             spare_off,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             op_done,
    output logic [IDX_W-1:0] buf_idx,
    output logic             at_last,
    output logic             page_adv
);

    localparam int SPARE_W  = $clog2(SPARE_BYTES);
    localparam int LAST_ALL = MAIN_BYTES + SPARE_BYTES - 1;

    area_e              area_q;
    logic [IDX_W-1:0]   load_idx;
    logic [IDX_W-1:0]   end_col;
    logic [IDX_W-1:0]   wrap_idx;
    logic [SPARE_W-1:0] start_q;

    pbp_area_ctl u_area (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .sel_vld   (sel_vld),
        .sel_code  (sel_code),
        .spare_off (spare_off),
        .col_load  (col_load),
        .op_done   (op_done),
        .area_q    (area_q)
    );

    pbp_span #(
        .MAIN_BYTES  (MAIN_BYTES),
        .SPARE_BYTES (SPARE_BYTES),
        .COL_W       (COL_W),
        .SPARE_W     (SPARE_W),
        .IDX_W       (IDX_W)
    ) u_span (
        .area        (area_q),
        .spare_off   (spare_off),
        .col_byte    (col_byte),
        .spare_start (start_q),
        .load_idx    (load_idx),
        .end_col     (end_col),
        .wrap_idx    (wrap_idx)
    );

    pbp_col_ctr #(
        .IDX_W    (IDX_W),
        .SPARE_W  (SPARE_W),
        .LAST_ALL (LAST_ALL)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .col_load   (col_load),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .load_idx   (load_idx),
        .load_start (col_byte[SPARE_W-1:0]),
        .end_col    (end_col),
        .wrap_idx   (wrap_idx),
        .idx_q      (buf_idx),
        .start_q    (start_q),
        .adv_q      (page_adv),
        .at_end     (at_last)
    );

endmodule

// File: rtl/pbp_checker.sv
// Temporal checks on the pointer ports, bound to page_ptr_unit.
module pbp_checker #(
    parameter int IDX_W    = 10,
    parameter int LAST_ALL = 527
)(
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             col_load,
    input logic             rd_stb,
    input logic             wr_stb,
    input logic [IDX_W-1:0] buf_idx,
    input logic             at_last,
    input logic             page_adv
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LAST_ALL);

    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (buf_idx == '0 && !page_adv)); // R1

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !col_load && !soft_rst && !at_last) |=> (buf_idx == $past(buf_idx) + 1'b1)); // R6

    AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !col_load && !soft_rst && at_last) |=> page_adv); // R8

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        page_adv |-> ($past(rd_stb) && $past(at_last))); // R8

    AST_WRITE_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !rd_stb && !col_load && !soft_rst && buf_idx == TOP_IDX) |=> (buf_idx == TOP_IDX)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !wr_stb && !col_load && !soft_rst) |=> $stable(buf_idx)); // R12

endmodule

bind page_ptr_unit pbp_checker #(
    .IDX_W    (IDX_W),
    .LAST_ALL (MAIN_BYTES + SPARE_BYTES - 1)
) u_pbp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .col_load (col_load),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .buf_idx  (buf_idx),
    .at_last  (at_last),
    .page_adv (page_adv)
);

// File: tb/page_ptr_unit_test.sv
module page_ptr_unit_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       sv;
        logic [1:0] sc;
        logic       ld;
        logic [7:0] col;
        logic       rd;
        logic       wr;
        logic       od;
        logic       so;
        logic [9:0] ei;
        logic       el;
        logic       ea;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 45;
    // fields: sel, code, load, col, rd, wr, op_done, spare_off | idx, last, adv | req
    localparam vec_t VECS [NV] = '{
        '{1'b1,2'd0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 10'd0,  1'b0,1'b0, 4'd2}, // R2 select lower
        '{1'b0,2'd0,1'b1,8'h10,1'b0,1'b0,1'b0,1'b1, 10'd16, 1'b0,1'b0, 4'd2}, // R2 load
        '{1'b0,2'd0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1, 10'd17, 1'b0,1'b0, 4'd6}, // R6
        '{1'b0,2'd0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1, 10'd18, 1'b0,1'b0, 4'd6}, // R6
        '{1'b0,2'd0,1'b1,8'hFE,1'b0,1'b0,1'b0,1'b1, 10'd254,1'b0,1'b0, 4'd2}, // R2
        '{1'b0,2'd0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1, 10'd255,1'b0,1'b0, 4'd6}, // R6
        '{1'b0,2'd0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1, 10'd256,1'b0,1'b0, 4'd6}, // R6 across halves
        '{1'b1,2'd1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 10'd256,1'b0,1'b0, 4'd3}, // R3 select upper
        '{1'b0,2'd0,1'b1,8'h05,1'b0,1'b0,1'b0,1'b1, 10'd261,1'b0,1'b0, 4'd3}, // R3 upper load
        '{1'b0,2'd0,1'b1,8'h05,1'b0,1'b0,1'b0,1'b1, 10'd5,  1'b0,1'b0, 4'd3}, // R3 fallback
        '{1'b1,2'd1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 10'd5,  1'b0,1'b0, 4'd3}, // R3
        '{1'b0,2'd0,1'b1,8'hFF,1'b0,1'b0,1'b0,1'b1, 10'd511,1'b1,1'b0, 4'd7}, // R7 end 511
        '{1'b0,2'd0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1, 10'd0,  1'b0,1'b1, 4'd8}, // R8 wrap
        '{1'b0,2'd0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 10'd0,  1'b0,1'b0, 4'd8}, // R8 one cycle
        '{1'b1,2'd1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 10'd0,  1'b0,1'b0, 4'd3}, // R3
        '{1'b0,2'd0,1'b1,8'hFF,1'b0,1'b0,1'b0,1'b0, 10'd511,1'b0,1'b0, 4'd7}, // R7 end 527
        '{1'b0,2'd0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 10'd512,1'b0,1'b0, 4'd7}, // R7 no wrap
        '{1'b1,2'd2,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 10'd512,1'b0,1'b0, 4'd4}, // R4 select spare
        '{1'b0,2'd0,1'b1,8'hFE,1'b0,1'b0,1'b0,1'b0, 10'd526,1'b0,1'b0, 4'd4}, // R4 upper nibble ignored
        '{1'b0,2'd0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 10'd527,1'b1,1'b0, 4'd7}, // R7
        '{1'b0,2'd0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 10'd526,1'b0,1'b1, 4'd9}, // R9 spare wrap
        '{1'b0,2'd0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 10'd527,1'b1,1'b0, 4'd9}, // R9
        '{1'b1,2'd0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 10'd527,1'b1,1'b0, 4'd7}, // R7 beyond 511
        '{1'b1,2'd2,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 10'd527,1'b1,1'b0, 4'd5}, // R5 refused
        '{1'b0,2'd0,1'b1,8'h03,1'b0,1'b0,1'b0,1'b1, 10'd3,  1'b0,1'b0, 4'd5}, // R5 still lower
        '{1'b1,2'd2,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 10'd3,  1'b0,1'b0, 4'd4}, // R4
        '{1'b0,2'd0,1'b1,8'h0F,1'b0,1'b0,1'b0,1'b0, 10'd527,1'b1,1'b0, 4'd4}, // R4
        '{1'b0,2'd0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0, 10'd527,1'b1,1'b0, 4'd10},// R10 saturate
        '{1'b0,2'd0,1'b1,8'h0E,1'b0,1'b0,1'b0,1'b0, 10'd526,1'b0,1'b0, 4'd4}, // R4
        '{1'b0,2'd0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0, 10'd527,1'b1,1'b0, 4'd10},// R10
        '{1'b0,2'd0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0, 10'd527,1'b1,1'b0, 4'd10},// R10
        '{1'b0,2'd0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0, 10'd527,1'b1,1'b0, 4'd11},// R11 spare kept
        '{1'b0,2'd0,1'b1,8'h01,1'b0,1'b0,1'b0,1'b0, 10'd513,1'b0,1'b0, 4'd11},// R11
        '{1'b1,2'd1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 10'd513,1'b0,1'b0, 4'd11},// R11
        '{1'b0,2'd0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0, 10'd513,1'b0,1'b0, 4'd11},// R11 upper drops
        '{1'b0,2'd0,1'b1,8'h01,1'b0,1'b0,1'b0,1'b0, 10'd1,  1'b0,1'b0, 4'd11},// R11
        '{1'b1,2'd0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 10'd1,  1'b0,1'b0, 4'd11},// R11
        '{1'b0,2'd0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0, 10'd1,  1'b0,1'b0, 4'd11},// R11
        '{1'b0,2'd0,1'b1,8'h02,1'b0,1'b0,1'b0,1'b0, 10'd2,  1'b0,1'b0, 4'd11},// R11 lower kept
        '{1'b0,2'd0,1'b1,8'h20,1'b1,1'b0,1'b0,1'b0, 10'd32, 1'b0,1'b0, 4'd12},// R12 load beats read
        '{1'b0,2'd0,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0, 10'd33, 1'b0,1'b0, 4'd12},// R12 read beats write
        '{1'b0,2'd0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0, 10'd34, 1'b0,1'b0, 4'd10},// R10
        '{1'b1,2'd2,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 10'd34, 1'b0,1'b0, 4'd4}, // R4
        '{1'b1,2'd3,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 10'd34, 1'b0,1'b0, 4'd2}, // R2 code 11
        '{1'b0,2'd0,1'b1,8'h04,1'b0,1'b0,1'b0,1'b0, 10'd516,1'b0,1'b0, 4'd2}  // R2 spare kept
    };

    logic       clk = 1'b0;
    logic       rst_n, soft_rst, sel_vld, col_load, spare_off, rd_stb, wr_stb, op_done;
    logic [1:0] sel_code;
    logic [7:0] col_byte;
    logic [9:0] buf_idx;
    logic       at_last, page_adv;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_ptr_unit uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sel_vld(sel_vld),
        .sel_code(sel_code), .col_load(col_load), .col_byte(col_byte),
        .spare_off(spare_off), .rd_stb(rd_stb), .wr_stb(wr_stb), .op_done(op_done),
        .buf_idx(buf_idx), .at_last(at_last), .page_adv(page_adv)
    );

    task automatic idle_inputs();
        sel_vld = 0; sel_code = 0; col_load = 0; col_byte = 0;
        rd_stb = 0; wr_stb = 0; op_done = 0; soft_rst = 0;
    endtask

    task automatic check(input int req, input int ei, input logic el, input logic ea);
        checks++;
        if (buf_idx !== 10'(ei) || at_last !== el || page_adv !== ea) begin
            errors++;
            $display("FAIL R%0d: idx=%0d last=%0b adv=%0b expected idx=%0d last=%0b adv=%0b",
                     req, buf_idx, at_last, page_adv, ei, el, ea);
        end
    endtask

    // Drive one vector at a falling edge; outputs settle by the next falling edge.
    task automatic apply(input vec_t v);
        sel_vld = v.sv; sel_code = v.sc; col_load = v.ld; col_byte = v.col;
        rd_stb = v.rd; wr_stb = v.wr; op_done = v.od; spare_off = v.so;
        @(negedge clk);
        idle_inputs();
    endtask

    function automatic vec_t mk(input logic sv, input logic [1:0] sc, input logic ld,
                                input logic [7:0] col, input logic rd, input logic wr,
                                input logic so);
        vec_t v;
        v = '0;
        v.sv = sv; v.sc = sc; v.ld = ld; v.col = col; v.rd = rd; v.wr = wr; v.so = so;
        return v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R0: watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        spare_off = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(1, 0, 1'b0, 1'b0); // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check(int'(VECS[i].req), int'(VECS[i].ei), VECS[i].el, VECS[i].ea);
        end

        // R7 / R8: full read across the spare tail with spare enabled, from the upper half
        apply(mk(1'b1, 2'd1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0));
        apply(mk(1'b0, 2'd0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0));
        check(7, 511, 1'b0, 1'b0);
        for (int k = 1; k <= 16; k++) begin
            apply(mk(1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0));
            check(7, 511 + k, (k == 16), 1'b0);
        end
        apply(mk(1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0));
        check(8, 0, 1'b0, 1'b1); // R8 wrap to column zero

        // R1: reset command clears index and area
        apply(mk(1'b1, 2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0));
        apply(mk(1'b0, 2'd0, 1'b1, 8'h05, 1'b0, 1'b0, 1'b0));
        check(4, 517, 1'b0, 1'b0);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check(1, 0, 1'b0, 1'b0);
        apply(mk(1'b0, 2'd0, 1'b1, 8'h07, 1'b0, 1'b0, 1'b0));
        check(1, 7, 1'b0, 1'b0); // R1 back in lower half

        // R1: hardware reset mid-run
        apply(mk(1'b1, 2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0));
        apply(mk(1'b0, 2'd0, 1'b1, 8'h09, 1'b0, 1'b0, 1'b0));
        check(4, 521, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(1, 0, 1'b0, 1'b0);
        apply(mk(1'b0, 2'd0, 1'b1, 8'h07, 1'b0, 1'b0, 1'b0));
        check(1, 7, 1'b0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule